// File: doc/BRIEF.md
# Bidirectional Pin Port with Direction Control

This block is an eight-pin general purpose I/O port on a simple byte-wide I/O bus. Software programs it through three registers. The drive register holds the value an output pin drives. The mode register picks input or output for each pin. The sense register is read-only and returns the synchronised pin levels.

Each pin connects to a pad through four signals: an output value, an output enable, a pull-up enable and an input value. A pin set as an input can have its pull-up switched on by writing a 1 to its drive bit. Pad inputs pass through two flops before they reach the sense register, which makes them safe to read from asynchronous pins.

Top module: `pin_port`

## Requirements
- R1: After reset, the drive and mode registers read 0x00. Every pad has its output enable and pull-up enable low.
- R2: A write with `bus_we` high updates the addressed register at the next clock edge. The sense register is at address 0x16, the mode register at 0x17 and the drive register at 0x18.
- R3: Reads are combinational. Reading 0x17 returns the last byte written to the mode register, and reading 0x18 returns the last byte written to the drive register.
- R4: Mode bit value 1 makes a pin an output, so `pad_oe[i]` equals mode bit i. Mode bit value 0 makes the pin an input with its pad output disabled.
- R5: `pad_out[i]` equals drive bit i whenever mode bit i is 1.
- R6: `pad_pu[i]` is 1 exactly when mode bit i is 0 and drive bit i is 1. An output pin never has its pull-up on.
- R7: The sense register at 0x16 returns the pad input levels as they were two clock edges earlier.
- R8: A write to 0x16 has no effect on the drive register, the mode register or any pad output.
- R9: A read from any address other than 0x16, 0x17 and 0x18 returns 0x00. A write to any such address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | I/O register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
The bench targets the pull-up rule by writing drive and mode bytes that cover every combination of the two bits. A design that lets output pins keep their pull-up, or that ignores the drive bit, shows the wrong `pad_pu`. It checks sense latency at exactly two edges, which catches a missing or extra flop stage. It writes to the read-only address and to unmapped addresses, which catches address decode that aliases or write strobes that leak into the drive or mode register. Random traffic across the whole address space keeps a model of both registers and compares every read against it.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
    localparam int WIDTH  = 8;
    localparam int AW     = 6;
    localparam logic [AW-1:0] ADDR_SENSE = 6'h16;
    localparam logic [AW-1:0] ADDR_MODE  = 6'h17;
    localparam logic [AW-1:0] ADDR_DRIVE = 6'h18;

    typedef struct packed {
        logic [WIDTH-1:0] drive;
        logic [WIDTH-1:0] mode;
    } ctrl_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pin_pad_ctrl.sv
module pin_pad_ctrl #(
    parameter int W = 8
) (
    input  logic [W-1:0] drive,
    input  logic [W-1:0] mode,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            pad_oe[i]  = mode[i];
            pad_out[i] = mode[i] & drive[i];
            pad_pu[i]  = ~mode[i] & drive[i];
        end
    end

    // R6
    always_comb begin
        pu_exclusive_chk: assert ((pad_pu & pad_oe) == '0);
    end
endmodule

// File: rtl/pin_port.sv
module pin_port
    import pin_port_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_we,
    output logic [7:0]    bus_rdata,
    input  logic [7:0]    pad_in,
    output logic [7:0]    pad_out,
    output logic [7:0]    pad_oe,
    output logic [7:0]    pad_pu
);
    ctrl_t ctrl_d, ctrl_q;
    logic [WIDTH-1:0] sense_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_we) begin
            if (bus_addr == ADDR_DRIVE) ctrl_d.drive = bus_wdata;
            if (bus_addr == ADDR_MODE)  ctrl_d.mode  = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_SENSE: bus_rdata = sense_q;
            ADDR_MODE:  bus_rdata = ctrl_q.mode;
            ADDR_DRIVE: bus_rdata = ctrl_q.drive;
            default:    bus_rdata = '0;
        endcase
    end

    pin_sync #(.W(WIDTH), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(sense_q)
    );

    pin_pad_ctrl #(.W(WIDTH)) u_pads (
        .drive(ctrl_q.drive), .mode(ctrl_q.mode),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // R8, R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == ADDR_MODE || bus_addr == ADDR_DRIVE))
        |=> $stable(ctrl_q));

    // R2
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_MODE) |=> (pad_oe == $past(bus_wdata)));

    // R5
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & pad_oe) == (ctrl_q.drive & pad_oe)));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > ADDR_DRIVE || bus_addr < ADDR_SENSE) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/pin_port_bench.sv
module pin_port_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [5:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic       bus_we = 0;
    logic [7:0] bus_rdata, pad_in = 0, pad_out, pad_oe, pad_pu;
    int checks = 0, failures = 0;
    logic [7:0] m_drive = 0, m_mode = 0;

    always #2 clk = ~clk;

    pin_port u_pin_port (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_pu(logic [7:0] d, logic [7:0] m);
        return d & ~m;
    endfunction

    function automatic logic [7:0] exp_read(logic [5:0] a);
        case (a)
            6'h17: return m_mode;
            6'h18: return m_drive;
            default: return 8'h00;
        endcase
    endfunction

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
        if (a == 6'h17) m_mode = d;
        if (a == 6'h18) m_drive = d;
    endtask

    task automatic rd(string req, logic [5:0] a);
        bus_addr = a; #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic pads(string req);
        chk({req, " oe"}, pad_oe, m_mode);
        chk({req, " out"}, pad_out & pad_oe, m_drive & m_mode);
        chk({req, " pu"}, pad_pu, exp_pu(m_drive, m_mode));
    endtask

    initial begin
        #50000;
        failures++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd("R1", 6'h17); rd("R1", 6'h18); pads("R1");
        // R6: every drive/mode combination across four pins
        wr(6'h18, 8'b1100_1100); wr(6'h17, 8'b1010_1010);
        rd("R3", 6'h17); rd("R3", 6'h18); pads("R6");
        pads("R4"); pads("R5");
        // R8: writing the sense address changes nothing
        wr(6'h16, 8'hFF);
        rd("R8", 6'h17); rd("R8", 6'h18); pads("R8");
        // R9: unmapped writes and reads
        wr(6'h19, 8'h5A); wr(6'h15, 8'hA5); wr(6'h00, 8'h77);
        rd("R9", 6'h19); rd("R9", 6'h15); rd("R9", 6'h3F); pads("R9");
        // R7: two-edge latency
        @(negedge clk); pad_in = 8'h3C;
        bus_addr = 6'h16;
        @(negedge clk); chk("R7 one edge", bus_rdata, 8'h00);
        @(negedge clk); chk("R7 two edges", bus_rdata, 8'h3C);
        for (int k = 0; k < 20; k++) begin
            logic [7:0] v = 8'($urandom);
            pad_in = v;
            @(negedge clk); @(negedge clk);
            bus_addr = 6'h16; #1;
            chk("R7", bus_rdata, v);
        end
        // R2: random traffic
        for (int k = 0; k < 300; k++) begin
            logic [5:0] a = 6'h14 + 6'($urandom_range(0, 6));
            if ($urandom_range(0, 3) == 0) a = 6'($urandom);
            if ($urandom_range(0, 1) == 1) wr(a, 8'($urandom));
            if (a != 6'h16) rd("R2", a);
            pads("R2");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule